// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer with Atomic Byte Access

This block is a 16-bit up-counting timer that sits on a byte-wide register bus. Next to the counter it holds two compare registers and one capture register. Every 16-bit register appears as a pair of byte addresses, low byte at the even address and high byte at the odd one. One shared 8-bit holding register lets software move all 16 bits of a register in a single clock. To write, software sends the high byte first and then the low byte. To read, it fetches the low byte first and then the high byte.

The counter advances only on clocks where the tick enable is high. It wraps to zero either past its full range or, in capture-limited mode, after reaching the capture value. Each compare channel watches the counter on tick clocks. On a match it raises a one-clock interrupt pulse and toggles its waveform output. A software write to the counter masks matches on the following tick. The capture channel synchronises a pin and an alternate input, takes the selected one, and on its rising edge stores the counter and pulses its interrupt.

Top module: `t16_timer`

## Requirements
- R1: After reset the counter, the capture register, both compare registers, the holding register, the read data, both waveform outputs and all interrupt outputs are 0.
- R2: A write to an odd (high-byte) address stores the data only in the shared holding register. A write to the matching even (low-byte) address loads {holding, write data} into the 16-bit register in one clock. The holding register is shared, so a low-byte read between the two writes changes the high byte that gets committed.
- R3: A read of an even address returns that register's low byte and copies its high byte into the holding register. A read of any odd address returns the holding register. This gives a consistent 16-bit snapshot even when the counter moves between the two reads.
- R4: The byte addresses are counter 0x84/0x85, capture 0x86/0x87, compare A 0x88/0x89 and compare B 0x8A/0x8B (low/high). Read data appears on `rdata` one clock after the read strobe and holds until the next read. A read outside this window returns 0.
- R5: The counter changes only on clocks with `tick_en` high, except for a bus commit. A bus commit takes priority over the increment in the same clock.
- R6: With `top_from_cap` low, the counter steps from 0xFFFF to 0x0000.
- R7: With `top_from_cap` high, a tick that finds the counter equal to the capture register loads 0 instead of incrementing.
- R8: On a tick clock where the counter equals compare register k and no mask is active, `cmp_irq[k]` is high for exactly the next clock and `wave_out[k]` inverts at the same edge (bit 0 = A, bit 1 = B).
- R9: A bus commit to the counter masks compare matches in its own clock and on the next tick clock, for both channels.
- R10: `cap_pin` and `cap_alt` each pass through two flops. `cap_src_sel` = 0 picks the pin and 1 picks the alternate input. A rising edge of the picked source loads the counter into the capture register and pulses `cap_irq` for one clock.
- R11: The capture register can also be loaded from the bus. A capture event in the same clock wins over the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| tick_en | input | 1 | Timer clock enable |
| cap_pin | input | 1 | Asynchronous capture pin |
| cap_alt | input | 1 | Alternate (comparator) capture input |
| cap_src_sel | input | 1 | Capture source: 0 pin, 1 alternate |
| top_from_cap | input | 1 | Use capture register as counter limit |
| cmp_irq | output | 2 | Compare match pulses (bit 0 A, bit 1 B) |
| cap_irq | output | 1 | Capture event pulse |
| wave_out | output | 2 | Toggle-on-match waveforms (bit 0 A, bit 1 B) |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, so a 16-bit counter, and a register window based at 0x84. Because every register can be preloaded over the bus, the full-range wrap, the capture-limited wrap and the masked compare are each reached within a few ticks. The bench freezes the counter with `tick_en` low, so capture values are exact and do not depend on synchroniser latency. The snapshot test reads the low byte, runs the counter across a high-byte change, and then reads the high byte.

// File: rtl/t16_pkg.sv
package t16_pkg;
  // Register slots; the low address of slot i is BASE + 2*i.
  localparam int NUM_REGS = 4;
  localparam int IDX_CNT  = 0;
  localparam int IDX_CAP  = 1;
  localparam int IDX_CMP0 = 2;  // compare channels occupy consecutive slots
  localparam int NUM_CMP  = 2;
endpackage

// File: rtl/t16_bus_bridge.sv
module t16_bus_bridge #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h84,
  parameter int NREG = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [NREG-1:0][2*DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0]            rdata,
  output logic [NREG-1:0]              commit,
  output logic [2*DATA_W-1:0]          commit_val
);
  localparam int IDX_W = $clog2(NREG);
  localparam int SPAN  = 2 * NREG;

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic              hi_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] hold_q;

  assign off      = addr - BASE;
  assign in_range = off < ADDR_W'(SPAN);
  assign hi_sel   = off[0];
  assign idx      = off[IDX_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd_en) begin
        if (!in_range) begin
          rdata <= '0;
        end else if (hi_sel) begin
          rdata <= hold_q;
        end else begin
          rdata  <= reg_val[idx][DATA_W-1:0];
          hold_q <= reg_val[idx][2*DATA_W-1:DATA_W];
        end
      end
      if (wr_en && in_range && hi_sel) hold_q <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++)
      commit[i] = wr_en && in_range && !hi_sel && (idx == IDX_W'(i));
  end
  assign commit_val = {hold_q, wdata};

  // R3
  hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_range && hi_sel) |=> (rdata == $past(hold_q)));

  // R4
  out_of_window_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_range) |=> (rdata == '0));
endmodule

// File: rtl/t16_counter.sv
module t16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wval,
  input  logic             top_en,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             mask
);
  logic blk_q;
  logic top_hit;

  assign top_hit = top_en && (cnt == top_val);
  assign mask    = wr || blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      blk_q <= 1'b0;
    end else if (wr) begin
      cnt   <= wval;
      blk_q <= 1'b1;
    end else if (tick_en) begin
      blk_q <= 1'b0;
      cnt   <= top_hit ? '0 : cnt + 1'b1;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr) |=> $stable(cnt));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr && !top_hit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R7
  top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr && top_hit) |=> (cnt == '0));
endmodule

// File: rtl/t16_compare.sv
module t16_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             mask,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] ocr,
  output logic             irq,
  output logic             wave
);
  logic hit;

  assign hit = tick_en && !mask && (cnt == ocr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr  <= '0;
      irq  <= 1'b0;
      wave <= 1'b0;
    end else begin
      if (wr) ocr <= wval;
      irq <= hit;
      if (hit) wave <= ~wave;
    end
  end

  // R8
  wave_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (wave != $past(wave)));

  // R8
  no_tick_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !irq);
endmodule

// File: rtl/t16_capture.sv
module t16_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             alt,
  input  logic             sel,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cap,
  output logic             irq
);
  logic [1:0] sync1_q, sync2_q;
  logic       prev_q;
  logic       src;
  logic       rise;

  assign src  = sel ? sync2_q[1] : sync2_q[0];
  assign rise = src && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= 1'b0;
      irq     <= 1'b0;
      cap     <= '0;
    end else begin
      sync1_q <= {alt, pin};
      sync2_q <= sync1_q;
      prev_q  <= src;
      irq     <= rise;
      if (rise)    cap <= cnt;
      else if (wr) cap <= wval;
    end
  end

  // R10
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cap == $past(cnt)));

  // R11
  cap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !$past(wr)) |-> $stable(cap));
endmodule

// File: rtl/t16_timer.sv
module t16_timer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick_en,
  input  logic              cap_pin,
  input  logic              cap_alt,
  input  logic              cap_src_sel,
  input  logic              top_from_cap,
  output logic [1:0]        cmp_irq,
  output logic              cap_irq,
  output logic [1:0]        wave_out
);
  import t16_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  logic [NUM_REGS-1:0][CNT_W-1:0] reg_val;
  logic [NUM_REGS-1:0]            commit;
  logic [CNT_W-1:0]               commit_val;
  logic [CNT_W-1:0]               cnt, cap;
  logic                           mask;

  t16_bus_bridge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE), .NREG(NUM_REGS)) u_bridge (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .reg_val(reg_val), .rdata(rdata), .commit(commit), .commit_val(commit_val)
  );

  t16_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr(commit[IDX_CNT]), .wval(commit_val),
    .top_en(top_from_cap), .top_val(cap), .cnt(cnt), .mask(mask)
  );

  t16_capture #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst(rst), .pin(cap_pin), .alt(cap_alt), .sel(cap_src_sel), .cnt(cnt),
    .wr(commit[IDX_CAP]), .wval(commit_val), .cap(cap), .irq(cap_irq)
  );

  assign reg_val[IDX_CNT] = cnt;
  assign reg_val[IDX_CAP] = cap;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] ocr;
    t16_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .tick_en(tick_en), .mask(mask), .cnt(cnt),
      .wr(commit[IDX_CMP0+k]), .wval(commit_val), .ocr(ocr),
      .irq(cmp_irq[k]), .wave(wave_out[k])
    );
    assign reg_val[IDX_CMP0+k] = ocr;
  end

  // R9
  cnt_write_block_chk: assert property (@(posedge clk) disable iff (rst)
    commit[IDX_CNT] |=> (cmp_irq == '0));

  // R2
  hi_write_only_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(|commit)) |=> ($stable(cnt) || $past(tick_en)));
endmodule

// File: tb/test_t16_timer.sv
module test_t16_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic       tick_en = 1'b0, cap_pin = 1'b0, cap_alt = 1'b0, cap_src_sel = 1'b0, top_from_cap = 1'b0;
  logic [1:0] cmp_irq, wave_out;
  logic       cap_irq;

  int checks = 0, fails = 0;
  int n_a = 0, n_b = 0, n_cap = 0;
  logic done = 1'b0;

  t16_timer i_t16_timer (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .tick_en(tick_en), .cap_pin(cap_pin), .cap_alt(cap_alt),
    .cap_src_sel(cap_src_sel), .top_from_cap(top_from_cap), .cmp_irq(cmp_irq),
    .cap_irq(cap_irq), .wave_out(wave_out)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(negedge clk) if (!rst) begin
    if (cmp_irq[0]) n_a++;
    if (cmp_irq[1]) n_b++;
    if (cap_irq)    n_cap++;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr16(input logic [7:0] lo, input logic [15:0] v);
    bus_wr(lo + 8'd1, v[15:8]);
    bus_wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_rd(lo, l);
    bus_rd(lo + 8'd1, h);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic pulse(input logic use_alt);
    @(negedge clk); if (use_alt) cap_alt = 1'b1; else cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    cap_alt = 1'b0; cap_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // {is_read, addr, wdata, expected}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h89, 8'hAB, 8'h00},
    {1'b1, 8'h88, 8'h00, 8'h00},  // high write alone not committed
    {1'b1, 8'h89, 8'h00, 8'h00},  // low read reloaded holding with 00
    {1'b0, 8'h88, 8'hCD, 8'h00},  // commits 00CD (shared holding)
    {1'b1, 8'h88, 8'h00, 8'hCD},
    {1'b1, 8'h89, 8'h00, 8'h00},
    {1'b0, 8'h89, 8'hAB, 8'h00},
    {1'b0, 8'h88, 8'hCD, 8'h00},
    {1'b1, 8'h88, 8'h00, 8'hCD},
    {1'b1, 8'h89, 8'h00, 8'hAB},
    {1'b0, 8'h8B, 8'h12, 8'h00},
    {1'b0, 8'h8A, 8'h34, 8'h00},
    {1'b1, 8'h8A, 8'h00, 8'h34},
    {1'b1, 8'h8B, 8'h00, 8'h12},
    {1'b0, 8'h87, 8'h56, 8'h00},
    {1'b0, 8'h86, 8'h78, 8'h00},
    {1'b1, 8'h86, 8'h00, 8'h78},
    {1'b1, 8'h87, 8'h00, 8'h56},
    {1'b1, 8'h8C, 8'h00, 8'h00}   // outside the window
  };

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", {8'h00, rdata}, 16'h0000);
    check("R1 wave_out", {14'd0, wave_out}, 16'h0000);
    check("R1 irqs", {13'd0, cmp_irq, cap_irq}, 16'h0000);
    rd16(8'h84, v); check("R1 counter", v, 16'h0000);
    rd16(8'h86, v); check("R1 capture", v, 16'h0000);

    // R2 R3 R4 R11 register table, counter frozen
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_rd(VEC[i][23:16], b);
        check($sformatf("R2/R3/R4/R11 vec %0d", i), {8'h00, b}, {8'h00, VEC[i][7:0]});
      end else begin
        bus_wr(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // R5: frozen counter, two reads equal
    wr16(8'h84, 16'hFFFE);
    rd16(8'h84, v); check("R5 frozen", v, 16'hFFFE);
    rd16(8'h84, v); check("R5 still frozen", v, 16'hFFFE);

    // R6 full-range wrap
    ticks(3);
    rd16(8'h84, v); check("R6 wrap", v, 16'h0001);

    // R3 snapshot across a high-byte change
    wr16(8'h84, 16'h00FF);
    bus_rd(8'h84, b); check("R3 snap low", {8'h00, b}, 16'h00FF);
    ticks(5);
    bus_rd(8'h85, b); check("R3 snap high", {8'h00, b}, 16'h0000);
    rd16(8'h84, v); check("R5 tick count", v, 16'h0104);

    // R7 capture-limited wrap
    wr16(8'h86, 16'h0020);
    top_from_cap = 1'b1;
    wr16(8'h84, 16'h001E);
    ticks(4);
    rd16(8'h84, v); check("R7 top wrap", v, 16'h0001);
    top_from_cap = 1'b0;

    // R8 R9 compare with running counter and masked first tick
    wr16(8'h88, 16'h0012);
    wr16(8'h8A, 16'h0010);
    check("R8 pre count", n_a[15:0] + n_b[15:0], 16'd0);
    @(negedge clk); tick_en = 1'b1;
    wr16(8'h84, 16'h0010);
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    check("R8 wave A toggled", {15'd0, wave_out[0]}, 16'd1);
    check("R8 irq A once", n_a[15:0], 16'd1);
    check("R9 B masked after write", n_b[15:0], 16'd0);
    check("R9 wave B held", {15'd0, wave_out[1]}, 16'd0);

    // R9 masked tick after a write with tick off
    wr16(8'h84, 16'h0012);
    ticks(1);
    @(negedge clk);
    check("R9 masked tick", n_a[15:0], 16'd1);
    // R8 unmasked second tick
    wr16(8'h84, 16'h0011);
    ticks(2);
    @(negedge clk);
    check("R8 second match", n_a[15:0], 16'd2);
    check("R8 wave A back", {15'd0, wave_out[0]}, 16'd0);

    // R10 capture source selection
    wr16(8'h84, 16'h1234);
    pulse(1'b0);
    rd16(8'h86, v); check("R10 pin capture", v, 16'h1234);
    check("R10 cap irq", n_cap[15:0], 16'd1);
    wr16(8'h84, 16'h5678);
    pulse(1'b1);
    rd16(8'h86, v); check("R10 alt ignored sel0", v, 16'h1234);
    @(negedge clk); cap_src_sel = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1'b0);
    rd16(8'h86, v); check("R10 pin ignored sel1", v, 16'h1234);
    pulse(1'b1);
    rd16(8'h86, v); check("R10 alt capture", v, 16'h5678);
    check("R10 cap irq total", n_cap[15:0], 16'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule